// File: doc/BRIEF.md
# Alarm Status and Interrupt Controller

This block gathers a bank of asynchronous alarm conditions and presents them to a host through a small synchronous register port. For each condition the host sees three things: the present level of the condition, a sticky flag that records that the condition came on, and a second sticky flag that records that it went away again. Both sticky flags fire on edges of the synchronized condition. Once the host clears one, it stays clear until a new edge arrives, however long the condition persists.

The host clears sticky flags by writing ones to them. Two mask registers, one for onset flags and one for recovery flags, select which flags may pull the active-low interrupt output. The interrupt goes high again as soon as no enabled flag remains set, whether or not the alarm itself is still present. Register map (3-bit address): 0 live levels (read-only), 1 onset flags (write-1-to-clear), 2 recovery flags (write-1-to-clear), 3 onset mask, 4 recovery mask. Bit i of every register belongs to condition i.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: Address 0 reads the live level of each condition after a two-flop synchronizer. Writes to address 0 have no effect on any register.
- R2: Reading any address leaves every onset and recovery flag unchanged.
- R3: A 0-to-1 change on `raw_cond[i]` sets onset flag bit i on the third rising clock edge after the input changes.
- R4: A 1-to-0 change on `raw_cond[i]` sets recovery flag bit i with the same latency as R3. The onset flag is not set by it.
- R5: Writing a 1 to a bit of address 1 or 2 clears that flag. Writing a 0 leaves that flag unchanged.
- R6: A cleared flag is not set again while its condition holds a steady level. Only a new edge sets it.
- R7: Addresses 3 (onset mask) and 4 (recovery mask) are read/write. A mask bit of 1 enables the matching flag onto the interrupt.
- R8: `irq_n` goes low one clock after any flag is set whose mask bit is 1.
- R9: `irq_n` is high one clock after no enabled flag remains set, even if the condition is still active. Flags whose mask bit is 0 never pull it low.
- R10: If an edge event and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.
- R11: After reset, all flags and masks read 0 and `irq_n` is 1.
- R12: `rd_data` is registered. It shows the register selected by `addr` one clock after that address is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_cond | input | N_COND | Raw alarm condition levels, asynchronous |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | N_COND | Write data |
| rd_data | output | N_COND | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sweeps every condition bit through rise and fall. For each one it checks that only the matching onset or recovery flag sets. A design that builds flags from levels instead of edges fails the re-set check: it re-flags a held alarm just after a clear. The bench also lands a clear in the exact cycle that an edge arrives, which catches a design where the clear wins and the event is lost. Each mask bit is enabled alone while other bits toggle, which exposes a wrong aggregation or mask slice. Finally, the bench clears a flag while its alarm is still high and expects `irq_n` to go high, which exposes an interrupt that follows the raw level.

// File: rtl/alarm_irq_pkg.sv
// Package: register selects shared by the alarm status block and its bench.
package alarm_irq_pkg;

    // Register select codes; the host-visible map depends on these values.
    typedef enum logic [2:0] {
        SEL_LIVE       = 3'd0,
        SEL_ONSET      = 3'd1,
        SEL_RECOV      = 3'd2,
        SEL_ONSET_MASK = 3'd3,
        SEL_RECOV_MASK = 3'd4
    } alarm_sel_e;

endpackage

// File: rtl/alarm_sync.sv
// Module: alarm_sync
// Brings N asynchronous condition levels into the clock domain through two
// flops. It keeps one more registered copy so that one-cycle rise and fall
// pulses can be formed. Assumes each raw input holds a level for several
// clocks; shorter glitches may be missed.
module alarm_sync #(
    parameter int N_COND = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] raw,
    output logic [N_COND-1:0] lvl,
    output logic [N_COND-1:0] rise,
    output logic [N_COND-1:0] fall
);
    logic [N_COND-1:0] meta_q;
    logic [N_COND-1:0] sync_q;
    logic [N_COND-1:0] prev_q;

    // Two-stage synchronizer followed by a history register for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge pulses compare the synchronized level with its previous value.
    always_comb begin
        lvl  = sync_q;
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
    end

endmodule

// File: rtl/alarm_event_latch.sv
// Module: alarm_event_latch
// A bank of sticky flags. A one-cycle set pulse sets a flag. A clear pulse
// clears it, and a set in the same cycle overrides the clear. Assumes the
// set pulses are edge events, so a held condition does not re-set a flag.
module alarm_event_latch #(
    parameter int N_COND = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] set,
    input  logic [N_COND-1:0] clr,
    output logic [N_COND-1:0] q
);
    for (genvar gi = 0; gi < N_COND; gi++) begin : g_bit
        logic flag_q;

        // Per-bit sticky flag; the set term is OR-ed last so it wins.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set[gi] | (flag_q & ~clr[gi]);
        end

        assign q[gi] = flag_q;

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[gi] |=> q[gi]); // R10
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[gi] && !set[gi]) |=> !q[gi]); // R5
        AST_ONLY_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q[gi]) |-> $past(set[gi])); // R6
    end

endmodule

// File: rtl/alarm_irq_ctrl.sv
// Module: alarm_irq_ctrl (top)
// Host-facing status block for a bank of alarm conditions. It provides live
// levels, onset flags and recovery flags (write-1-to-clear), two mask
// registers and an active-low interrupt. Assumes a single-cycle register port.
// Read data is registered, so it shows the selected register one clock after
// the address is presented.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int N_COND = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] raw_cond,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic [N_COND-1:0] wr_data,
    output logic [N_COND-1:0] rd_data,
    output logic              irq_n
);
    logic [N_COND-1:0] lvl, rise, fall;
    logic [N_COND-1:0] onset_q, recov_q;
    logic [N_COND-1:0] onset_clr, recov_clr;
    logic [N_COND-1:0] onset_mask_q, recov_mask_q;
    logic              pending;
    alarm_sel_e        sel;

    assign sel = alarm_sel_e'(addr);

    alarm_sync #(.N_COND(N_COND)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw_cond),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    alarm_event_latch #(.N_COND(N_COND)) u_onset (
        .clk(clk), .rst_n(rst_n), .set(rise), .clr(onset_clr), .q(onset_q)
    );

    alarm_event_latch #(.N_COND(N_COND)) u_recov (
        .clk(clk), .rst_n(rst_n), .set(fall), .clr(recov_clr), .q(recov_q)
    );

    // Write decode: clear strobes go only to the flag bank being addressed.
    always_comb begin
        onset_clr = (wr_en && sel == SEL_ONSET) ? wr_data : '0;
        recov_clr = (wr_en && sel == SEL_RECOV) ? wr_data : '0;
    end

    // Mask registers are plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            onset_mask_q <= '0;
            recov_mask_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_ONSET_MASK) onset_mask_q <= wr_data;
            if (sel == SEL_RECOV_MASK) recov_mask_q <= wr_data;
        end
    end

    // Registered read mux; reads have no side effects on any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            case (sel)
                SEL_LIVE:       rd_data <= lvl;
                SEL_ONSET:      rd_data <= onset_q;
                SEL_RECOV:      rd_data <= recov_q;
                SEL_ONSET_MASK: rd_data <= onset_mask_q;
                SEL_RECOV_MASK: rd_data <= recov_mask_q;
                default:        rd_data <= '0;
            endcase
        end
    end

    // Interrupt aggregation: any enabled flag pulls the output low.
    assign pending = |((onset_q & onset_mask_q) | (recov_q & recov_mask_q));

    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~pending;
    end

    AST_IRQ_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ((onset_q | recov_q) == '0) |=> irq_n); // R9
    AST_IRQ_IDLE_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (onset_mask_q == '0 && recov_mask_q == '0) |=> irq_n); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(|(onset_q | recov_q))); // R8
    AST_LIVE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LIVE) |=> ($stable(onset_mask_q) && $stable(recov_mask_q))); // R1

endmodule

// File: tb/sim_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module sim_alarm_irq_ctrl;
    import alarm_irq_pkg::*;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] raw_cond = '0;
    logic [2:0]   addr = 3'd0;
    logic         wr_en = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] rd_data;
    logic         irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alarm_irq_ctrl #(.N_COND(N)) u0 (
        .clk(clk), .rst_n(rst_n), .raw_cond(raw_cond), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        addr = a;
        step(1);
        d = rd_data;
    endtask

    initial begin
        logic [N-1:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R11 reset state
        check("R11 irq", {{(N-1){1'b0}}, irq_n}, 1);
        rd(SEL_ONSET, v);      check("R11 onset", v, 0);
        rd(SEL_RECOV, v);      check("R11 recov", v, 0);
        rd(SEL_ONSET_MASK, v); check("R11 omask", v, 0);
        rd(SEL_RECOV_MASK, v); check("R11 rmask", v, 0);

        // R3 R4 R5 per-bit sweep of onset and recovery
        for (int i = 0; i < N; i++) begin
            raw_cond[i] = 1'b1;
            step(3);
            rd(SEL_ONSET, v); check("R3 onset", v, N'(1) << i);
            rd(SEL_RECOV, v); check("R4 no recov on rise", v, 0);
            rd(SEL_LIVE, v);  check("R1 live", v, N'(1) << i);
            raw_cond[i] = 1'b0;
            step(3);
            rd(SEL_RECOV, v); check("R4 recov", v, N'(1) << i);
            wr(SEL_ONSET, 0);
            rd(SEL_ONSET, v); check("R5 write0 keeps", v, N'(1) << i);
            wr(SEL_ONSET, N'(1) << i);
            wr(SEL_RECOV, N'(1) << i);
            rd(SEL_ONSET, v); check("R5 onset cleared", v, 0);
            rd(SEL_RECOV, v); check("R5 recov cleared", v, 0);
        end

        // R6 held condition does not re-set; R2 reads leave flags alone
        raw_cond = 8'hA5;
        step(4);
        rd(SEL_ONSET, v); check("R3 multi onset", v, 8'hA5);
        rd(SEL_LIVE, v); rd(SEL_LIVE, v);
        rd(SEL_ONSET, v); check("R2 reads inert", v, 8'hA5);
        wr(SEL_ONSET, 8'hFF);
        step(5);
        rd(SEL_ONSET, v); check("R6 no re-set", v, 0);
        wr(SEL_LIVE, 8'hFF);
        rd(SEL_LIVE, v); check("R1 live ignores write", v, 8'hA5);
        raw_cond = 0;
        step(4);
        wr(SEL_RECOV, 8'hFF);

        // R7 masks read/write; R12 unmapped reads zero
        wr(SEL_ONSET_MASK, 8'h3C);
        wr(SEL_RECOV_MASK, 8'hC3);
        rd(SEL_ONSET_MASK, v); check("R7 omask", v, 8'h3C);
        rd(SEL_RECOV_MASK, v); check("R7 rmask", v, 8'hC3);
        rd(3'd6, v); check("R12 unmapped", v, 0);
        wr(SEL_ONSET_MASK, 0);
        wr(SEL_RECOV_MASK, 0);

        // R8 R9 single enabled mask bit against toggling of other bits
        for (int i = 0; i < N; i++) begin
            wr(SEL_ONSET_MASK, N'(1) << i);
            raw_cond = ~(N'(1) << i);
            step(5);
            check("R9 masked no irq", {{(N-1){1'b0}}, irq_n}, 1);
            raw_cond = '1;
            step(5);
            check("R8 irq low", {{(N-1){1'b0}}, irq_n}, 0);
            wr(SEL_ONSET, 8'hFF);
            step(1);
            check("R9 release while active", {{(N-1){1'b0}}, irq_n}, 1);
            raw_cond = '0;
            step(4);
            wr(SEL_RECOV, 8'hFF);
            wr(SEL_ONSET_MASK, 0);
        end

        // R8 recovery mask path
        wr(SEL_RECOV_MASK, 8'h01);
        raw_cond[0] = 1'b1; step(4);
        check("R8 onset unmasked", {{(N-1){1'b0}}, irq_n}, 1);
        raw_cond[0] = 1'b0; step(5);
        check("R8 recov irq", {{(N-1){1'b0}}, irq_n}, 0);
        wr(SEL_RECOV, 8'h01); wr(SEL_ONSET, 8'hFF); step(1);
        check("R9 recov release", {{(N-1){1'b0}}, irq_n}, 1);
        wr(SEL_RECOV_MASK, 0);

        // R10 edge and clear in the same cycle: set wins
        raw_cond[1] = 1'b1;
        step(2);
        wr(SEL_ONSET, 8'h02);
        rd(SEL_ONSET, v); check("R10 set wins", v, 8'h02);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule